// File: doc/BRIEF.md
# Command List Walker

This block runs a single DMA channel from a list of commands kept in memory. Software starts it by writing a pointer word: the byte address of a pointer list, shifted right by three. The walker reads the pointer entry at that address. The entry leads either to a descriptor list or to another pointer list. The walker then fetches each descriptor in turn and performs the copy it describes.

Each descriptor is one of two kinds. A four-word linear copy moves one contiguous run of bytes. A six-word box copy moves a number of rows, and after each row the source address and the destination address advance by separate strides. The row-length, row-count and stride words each hold a source value in their upper half and a destination value in their lower half.

Data moves one 32-bit word at a time through a simple request/response memory port. Each word is read and then written. The channel reports progress through a busy level and a done pulse. A start that arrives while the channel is busy is refused and recorded in a sticky flag.

Top module: `cmdlist_walker`

## Requirements
- R1: After reset, busy, done, overrun and mem_req are all 0.
- R2: When ptr_wr is high while the channel is idle, busy is 1 in the next cycle. The first memory read of the walk is at byte address {ptr_word, 3'b000}.
- R3: In a pointer entry, bit 29 set means that bits [28:0] shifted left by 3 give another pointer list, and the walker reads that list's first entry next. Bit 29 clear means that the same field gives the byte address of a descriptor list.
- R4: In a pointer entry, bit 31 marks the last entry. When the descriptor list of an entry without bit 31 ends, the walker reads the next pointer entry at the current entry address plus 4.
- R5: A descriptor whose command word has bits [1:0] equal to 3 is a box copy of 6 words: command, source, destination, row length, row count, stride. Any other type value is a linear copy of 4 words: command, source, destination, length. Command bit 31 marks the last descriptor. Otherwise the next descriptor starts right after the current one, 16 or 24 bytes later.
- R6: A linear copy moves ceil(length[15:0]/4) words. Word i is read from source+4i and written to destination+4i, in increasing order. A length of 0 causes no data access.
- R7: A box copy moves row_count[31:16] rows of ceil(row_length[31:16]/4) words each. After each row the source base advances by stride[31:16] and the destination base by stride[15:0]. The destination halves of row length and row count have no effect. A zero row count or a zero row length causes no data access.
- R8: Every data word is read before it is written, and no read of another word comes in between. A request with mem_ready low stays asserted, with address and direction unchanged, until it is accepted.
- R9: busy stays high until the walk ends. done is a one-cycle pulse, and busy is low in that same cycle. When the walk ends with a data write, done is high in the cycle that follows the cycle in which that write was accepted.
- R10: A ptr_wr while busy is ignored, so the walk in progress continues unchanged. It sets overrun, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr | input | 1 | Command-pointer write strobe |
| ptr_word | input | 29 | Pointer list byte address shifted right by 3 |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid (arrives after acceptance) |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| overrun | output | 1 | Sticky: start refused while busy |

## Verification
Linear copies of whole-word and odd byte lengths separate word rounding from plain length use. A box copy with different source and destination strides, and with unrelated values in the destination halves, shows that each half is steered to the correct side. Lists that mix both formats, span two pointer entries or pass through a chained pointer list exercise the descriptor stride and the pointer sequencing. Alternating acceptance, longer read latency, zero-length and zero-row descriptors, and a start issued mid-walk cover the handshake hold, the empty-copy completion and the refusal path.

// File: rtl/cmdwalk_pkg.sv
package cmdwalk_pkg;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = WORD_W / 2;
    localparam int CNT_W   = HALF_W;
    localparam int PTR_W   = WORD_W - 3;
    localparam int WIDX_W  = 3;

    localparam int ENT_LAST_BIT  = 31;
    localparam int ENT_CHAIN_BIT = 29;
    localparam int CMD_LAST_BIT  = 31;
    localparam logic [1:0] KIND_BOX = 2'd3;

    localparam logic [WIDX_W-1:0] LIN_LAST_IDX = 3'd3;
    localparam logic [WIDX_W-1:0] BOX_LAST_IDX = 3'd5;
    localparam logic [WORD_W-1:0] LIN_BYTES    = 32'd16;
    localparam logic [WORD_W-1:0] BOX_BYTES    = 32'd24;

    typedef enum logic [2:0] {
        L_IDLE, L_PTR_RD, L_PTR_WAIT, L_DSC_RD, L_DSC_WAIT, L_MOVE
    } list_st_e;

    typedef enum logic [1:0] {
        M_IDLE, M_RD, M_RWAIT, M_WR
    } mv_st_e;
endpackage

// File: rtl/cmdwalk_mover.sv
module cmdwalk_mover
    import cmdwalk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] src_base,
    input  logic [WORD_W-1:0] dst_base,
    input  logic [CNT_W-1:0]  row_words,
    input  logic [CNT_W-1:0]  row_count,
    input  logic [HALF_W-1:0] src_step,
    input  logic [HALF_W-1:0] dst_step,
    output logic              req,
    output logic              we,
    output logic [WORD_W-1:0] addr,
    output logic [WORD_W-1:0] wdata,
    input  logic              ready,
    input  logic              rvalid,
    input  logic [WORD_W-1:0] rdata,
    output logic              fin
);
    typedef struct packed {
        mv_st_e            st;
        logic [WORD_W-1:0] src_row;
        logic [WORD_W-1:0] dst_row;
        logic [CNT_W-1:0]  widx;
        logic [CNT_W-1:0]  rows_left;
        logic [WORD_W-1:0] data;
    } mv_regs_t;

    mv_regs_t q, d;
    logic [WORD_W-1:0] word_off;

    always_comb begin
        d        = q;
        fin      = 1'b0;
        req      = 1'b0;
        we       = 1'b0;
        word_off = WORD_W'(q.widx) << 2;
        addr     = q.src_row + word_off;
        wdata    = q.data;
        case (q.st)
            M_IDLE: begin
                if (start) begin
                    d.src_row   = src_base;
                    d.dst_row   = dst_base;
                    d.widx      = '0;
                    d.rows_left = row_count;
                    if (row_words == '0 || row_count == '0) begin
                        fin = 1'b1;
                    end else begin
                        d.st = M_RD;
                    end
                end
            end
            M_RD: begin
                req = 1'b1;
                if (ready) d.st = M_RWAIT;
            end
            M_RWAIT: begin
                if (rvalid) begin
                    d.data = rdata;
                    d.st   = M_WR;
                end
            end
            M_WR: begin
                req  = 1'b1;
                we   = 1'b1;
                addr = q.dst_row + word_off;
                if (ready) begin
                    if (q.widx == row_words - 1'b1) begin
                        d.widx = '0;
                        if (q.rows_left == CNT_W'(1)) begin
                            fin  = 1'b1;
                            d.st = M_IDLE;
                        end else begin
                            d.rows_left = q.rows_left - 1'b1;
                            d.src_row   = q.src_row + WORD_W'(src_step);
                            d.dst_row   = q.dst_row + WORD_W'(dst_step);
                            d.st        = M_RD;
                        end
                    end else begin
                        d.widx = q.widx + 1'b1;
                        d.st   = M_RD;
                    end
                end
            end
            default: d.st = M_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8: a stalled request keeps its address and direction
    p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ready) |=> (req && $stable(addr) && $stable(we)));

    // R8: an accepted write is never followed directly by another write
    p_read_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && ready) |=> !(req && we));
endmodule

// File: rtl/cmdwalk_list.sv
module cmdwalk_list
    import cmdwalk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_wr,
    input  logic [PTR_W-1:0]  ptr_word,
    output logic              req,
    output logic [WORD_W-1:0] addr,
    input  logic              ready,
    input  logic              rvalid,
    input  logic [WORD_W-1:0] rdata,
    output logic              mv_start,
    input  logic              mv_fin,
    output logic              is_box,
    output logic [WORD_W-1:0] f_src,
    output logic [WORD_W-1:0] f_dst,
    output logic [WORD_W-1:0] f_len,
    output logic [HALF_W-1:0] f_rows,
    output logic [WORD_W-1:0] f_step,
    output logic              busy,
    output logic              done,
    output logic              overrun
);
    typedef struct packed {
        list_st_e          st;
        logic [WORD_W-1:0] ptr_addr;
        logic [WORD_W-1:0] dsc_addr;
        logic [WIDX_W-1:0] widx;
        logic              last_ent;
        logic              box;
        logic              cmd_last;
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] len;
        logic [HALF_W-1:0] rows;
        logic [WORD_W-1:0] step;
        logic              start;
        logic              done;
        logic              ovr;
    } list_regs_t;

    list_regs_t q, d;
    logic              kind_box;
    logic [WIDX_W-1:0] last_idx;

    always_comb begin
        d        = q;
        d.start  = 1'b0;
        d.done   = 1'b0;
        req      = 1'b0;
        addr     = q.ptr_addr;
        kind_box = (q.widx == '0) ? (rdata[1:0] == KIND_BOX) : q.box;
        last_idx = kind_box ? BOX_LAST_IDX : LIN_LAST_IDX;
        if (ptr_wr && q.st != L_IDLE) d.ovr = 1'b1;
        case (q.st)
            L_IDLE: begin
                if (ptr_wr) begin
                    d.ptr_addr = {ptr_word, 3'b000};
                    d.st       = L_PTR_RD;
                end
            end
            L_PTR_RD: begin
                req = 1'b1;
                if (ready) d.st = L_PTR_WAIT;
            end
            L_PTR_WAIT: begin
                if (rvalid) begin
                    d.last_ent = rdata[ENT_LAST_BIT];
                    if (rdata[ENT_CHAIN_BIT]) begin
                        d.ptr_addr = {rdata[PTR_W-1:0], 3'b000};
                        d.st       = L_PTR_RD;
                    end else begin
                        d.dsc_addr = {rdata[PTR_W-1:0], 3'b000};
                        d.widx     = '0;
                        d.st       = L_DSC_RD;
                    end
                end
            end
            L_DSC_RD: begin
                req  = 1'b1;
                addr = q.dsc_addr + {{(WORD_W-WIDX_W-2){1'b0}}, q.widx, 2'b00};
                if (ready) d.st = L_DSC_WAIT;
            end
            L_DSC_WAIT: begin
                if (rvalid) begin
                    case (q.widx)
                        3'd0: begin
                            d.box      = kind_box;
                            d.cmd_last = rdata[CMD_LAST_BIT];
                        end
                        3'd1:    d.src  = rdata;
                        3'd2:    d.dst  = rdata;
                        3'd3:    d.len  = rdata;
                        3'd4:    d.rows = rdata[WORD_W-1:HALF_W];
                        3'd5:    d.step = rdata;
                        default: d.st   = L_IDLE;
                    endcase
                    if (q.widx == last_idx) begin
                        d.st    = L_MOVE;
                        d.start = 1'b1;
                    end else begin
                        d.widx = q.widx + 1'b1;
                        d.st   = L_DSC_RD;
                    end
                end
            end
            L_MOVE: begin
                if (mv_fin) begin
                    if (q.cmd_last) begin
                        if (q.last_ent) begin
                            d.st   = L_IDLE;
                            d.done = 1'b1;
                        end else begin
                            d.ptr_addr = q.ptr_addr + 32'd4;
                            d.st       = L_PTR_RD;
                        end
                    end else begin
                        d.dsc_addr = q.dsc_addr + (q.box ? BOX_BYTES : LIN_BYTES);
                        d.widx     = '0;
                        d.st       = L_DSC_RD;
                    end
                end
            end
            default: d.st = L_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mv_start = q.start;
    assign is_box   = q.box;
    assign f_src    = q.src;
    assign f_dst    = q.dst;
    assign f_len    = q.len;
    assign f_rows   = q.rows;
    assign f_step   = q.step;
    assign busy     = (q.st != L_IDLE);
    assign done     = q.done;
    assign overrun  = q.ovr;

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr && !busy) |=> busy);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_busy_fall_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    p_ovr_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr && busy) |=> overrun);
endmodule

// File: rtl/cmdlist_walker.sv
module cmdlist_walker
    import cmdwalk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_wr,
    input  logic [PTR_W-1:0]  ptr_word,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              overrun
);
    logic              l_req, m_req, m_we, mv_start, mv_fin, is_box;
    logic [WORD_W-1:0] l_addr, m_addr, m_wdata;
    logic [WORD_W-1:0] f_src, f_dst, f_len, f_step;
    logic [HALF_W-1:0] f_rows;
    logic [HALF_W-1:0] len_bytes;
    logic [CNT_W:0]    len_round;
    logic [CNT_W-1:0]  row_words, row_count;
    logic [HALF_W-1:0] src_step, dst_step;

    cmdwalk_list u_list (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_wr   (ptr_wr),
        .ptr_word (ptr_word),
        .req      (l_req),
        .addr     (l_addr),
        .ready    (mem_ready),
        .rvalid   (mem_rvalid),
        .rdata    (mem_rdata),
        .mv_start (mv_start),
        .mv_fin   (mv_fin),
        .is_box   (is_box),
        .f_src    (f_src),
        .f_dst    (f_dst),
        .f_len    (f_len),
        .f_rows   (f_rows),
        .f_step   (f_step),
        .busy     (busy),
        .done     (done),
        .overrun  (overrun)
    );

    // Steer the descriptor halves to the copy engine
    always_comb begin
        len_bytes = is_box ? f_len[WORD_W-1:HALF_W] : f_len[HALF_W-1:0];
        len_round = {1'b0, len_bytes} + (CNT_W+1)'(3);
        row_words = CNT_W'(len_round >> 2);
        row_count = is_box ? f_rows : CNT_W'(1);
        src_step  = is_box ? f_step[WORD_W-1:HALF_W] : '0;
        dst_step  = is_box ? f_step[HALF_W-1:0] : '0;
    end

    cmdwalk_mover u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (mv_start),
        .src_base  (f_src),
        .dst_base  (f_dst),
        .row_words (row_words),
        .row_count (row_count),
        .src_step  (src_step),
        .dst_step  (dst_step),
        .req       (m_req),
        .we        (m_we),
        .addr      (m_addr),
        .wdata     (m_wdata),
        .ready     (mem_ready),
        .rvalid    (mem_rvalid),
        .rdata     (mem_rdata),
        .fin       (mv_fin)
    );

    assign mem_req   = l_req | m_req;
    assign mem_we    = m_req & m_we;
    assign mem_addr  = m_req ? m_addr : l_addr;
    assign mem_wdata = m_wdata;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    p_one_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_req && m_req));

    p_port_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: tb/tb_cmdlist_walker.sv
`timescale 1ns/1ps
module tb_cmdlist_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr_wr = 1'b0;
    logic [28:0] ptr_word = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, done, overrun;

    always #5 clk = ~clk;

    cmdlist_walker dut (
        .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_word(ptr_word),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .overrun(overrun)
    );

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    exp_t        mon_e;
    logic [31:0] mem [0:1023];
    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    int          ready_mode = 0;
    int          rd_lat = 0;
    bit          rd_pend = 0;
    int          rd_cnt = 0;
    logic [31:0] rd_hold = '0;
    bit          arm_first = 0;
    logic [31:0] first_rd = '0;
    int          since_wr = 0;
    int          last_since = 0;
    int          done_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Memory model and scoreboard monitor, all on the falling edge
    always @(negedge clk) begin
        cyc++;
        since_wr++;
        mem_rvalid = 1'b0;
        if (rd_pend) begin
            if (rd_cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = rd_hold;
                rd_pend    = 0;
            end else begin
                rd_cnt--;
            end
        end
        mem_ready = (ready_mode == 0) ? 1'b1 : cyc[0];
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R6", "unexpected write addr", mem_addr, 32'h0);
                end else begin
                    mon_e = exp_q.pop_front();
                    chk(mem_addr == mon_e.a, mon_e.tag, "write address", mem_addr, mon_e.a);
                    chk(mem_wdata == mon_e.d, mon_e.tag, "write data", mem_wdata, mon_e.d);
                end
                mem[mem_addr[11:2]] = mem_wdata;
                since_wr = 0;
            end else begin
                rd_pend = 1;
                rd_cnt  = rd_lat;
                rd_hold = mem[mem_addr[11:2]];
                if (arm_first) begin
                    first_rd  = mem_addr;
                    arm_first = 0;
                end
            end
        end
        if (done) begin
            done_cnt++;
            last_since = since_wr;
        end
        if (cyc == 100000) begin
            fails++;
            checks++;
            $display("FAIL R9 watchdog: cycles=%0d expected < %0d", cyc, 100000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic put(input logic [31:0] a, input logic [31:0] v);
        mem[a[11:2]] = v;
    endtask

    task automatic lin_desc(input logic [31:0] at, input bit last, input logic [31:0] src,
                            input logic [31:0] dst, input logic [31:0] len);
        put(at, last ? 32'h8000_0000 : 32'h0);
        put(at + 4, src);
        put(at + 8, dst);
        put(at + 12, len);
    endtask

    task automatic box_desc(input logic [31:0] at, input bit last, input logic [31:0] src,
                            input logic [31:0] dst, input logic [31:0] rlen,
                            input logic [31:0] rows, input logic [31:0] step);
        put(at, last ? 32'h8000_0003 : 32'h0000_0003);
        put(at + 4, src);
        put(at + 8, dst);
        put(at + 12, rlen);
        put(at + 16, rows);
        put(at + 20, step);
    endtask

    task automatic push_lin(input logic [31:0] src, input logic [31:0] dst,
                            input int len, input string tag);
        exp_t e;
        for (int i = 0; i < (len + 3) / 4; i++) begin
            e.a = dst + 32'(4 * i);
            e.d = mem[(src >> 2) + 32'(i)];
            e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    task automatic push_box(input logic [31:0] src, input logic [31:0] dst, input int rlen,
                            input int rows, input int soff, input int doff, input string tag);
        exp_t e;
        for (int r = 0; r < rows; r++) begin
            for (int i = 0; i < (rlen + 3) / 4; i++) begin
                e.a = dst + 32'(r * doff + 4 * i);
                e.d = mem[((src + 32'(r * soff)) >> 2) + 32'(i)];
                e.tag = tag;
                exp_q.push_back(e);
            end
        end
    endtask

    task automatic walk(input logic [31:0] ptr_byte, input bit has_wr, input int poke_at,
                        input string tag);
        int d0;
        int n;
        @(negedge clk);
        #1;
        d0 = done_cnt;
        arm_first = 1;
        ptr_wr = 1'b1;
        ptr_word = ptr_byte[31:3];
        @(negedge clk);
        #1;
        ptr_wr = 1'b0;
        chk(busy == 1'b1, "R2", {tag, " busy after start"}, 32'(busy), 32'h1);
        n = 0;
        while (done_cnt == d0 && n < 5000) begin
            @(negedge clk);
            #1;
            ptr_wr = 1'b0;
            n++;
            if (n == poke_at) begin
                ptr_wr = 1'b1;
                ptr_word = 29'h8;
            end
        end
        ptr_wr = 1'b0;
        chk(done_cnt == d0 + 1, "R9", {tag, " done pulses"}, 32'(done_cnt - d0), 32'h1);
        chk(busy == 1'b0, "R9", {tag, " busy low at end"}, 32'(busy), 32'h0);
        chk(first_rd == ptr_byte, "R2", {tag, " first read address"}, first_rd, ptr_byte);
        chk(exp_q.size() == 0, "R4", {tag, " all expected writes seen"}, 32'(exp_q.size()), 32'h0);
        if (has_wr)
            chk(last_since == 1, "R9", {tag, " done after last write"}, 32'(last_since), 32'h1);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'(i) * 32'h9E37_79B1 + 32'h1234_5671;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy in reset", 32'(busy), 32'h0);
        chk(done == 1'b0, "R1", "done in reset", 32'(done), 32'h0);
        chk(overrun == 1'b0, "R1", "overrun in reset", 32'(overrun), 32'h0);
        chk(mem_req == 1'b0, "R1", "mem_req in reset", 32'(mem_req), 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk(busy == 1'b0 && mem_req == 1'b0, "R1", "idle after reset", 32'(busy), 32'h0);

        // R6: one linear copy of 20 bytes
        put(32'h040, 32'h8000_0000 | (32'h100 >> 3));
        lin_desc(32'h100, 1, 32'h800, 32'hA00, 20);
        push_lin(32'h800, 32'hA00, 20, "R6");
        walk(32'h040, 1, 0, "lin");

        // R8: two linear copies, odd length, alternating acceptance
        ready_mode = 1;
        put(32'h048, 32'h8000_0000 | (32'h140 >> 3));
        lin_desc(32'h140, 0, 32'h820, 32'hA40, 7);
        lin_desc(32'h150, 1, 32'h840, 32'hA60, 4);
        push_lin(32'h820, 32'hA40, 7, "R8");
        push_lin(32'h840, 32'hA60, 4, "R8");
        walk(32'h048, 1, 0, "stall");

        // R7: box copy with distinct strides and unrelated destination halves
        ready_mode = 0;
        rd_lat = 2;
        put(32'h050, 32'h8000_0000 | (32'h180 >> 3));
        box_desc(32'h180, 1, 32'h860, 32'hA80, (8 << 16) | 32'h44, (3 << 16) | 32'h9,
                 (16 << 16) | 12);
        push_box(32'h860, 32'hA80, 8, 3, 16, 12, "R7");
        walk(32'h050, 1, 0, "box");

        // R5 R4 R10: two pointer entries, mixed formats, start attempt mid-walk
        rd_lat = 0;
        ready_mode = 1;
        chk(overrun == 1'b0, "R10", "overrun clear before poke", 32'(overrun), 32'h0);
        put(32'h058, 32'h1C0 >> 3);
        put(32'h05C, 32'h8000_0000 | (32'h200 >> 3));
        box_desc(32'h1C0, 0, 32'h900, 32'hB00, (12 << 16) | 12, (2 << 16) | 2,
                 (32 << 16) | 16);
        lin_desc(32'h1D8, 1, 32'h940, 32'hB40, 8);
        lin_desc(32'h200, 1, 32'h960, 32'hB60, 12);
        push_box(32'h900, 32'hB00, 12, 2, 32, 16, "R5");
        push_lin(32'h940, 32'hB40, 8, "R5");
        push_lin(32'h960, 32'hB60, 12, "R4");
        walk(32'h058, 1, 6, "mixed");
        chk(overrun == 1'b1, "R10", "overrun set by start while busy", 32'(overrun), 32'h1);

        // R3: chained pointer list
        ready_mode = 0;
        put(32'h060, 32'h2000_0000 | (32'h068 >> 3));
        put(32'h068, 32'h8000_0000 | (32'h220 >> 3));
        lin_desc(32'h220, 1, 32'h980, 32'hB80, 16);
        push_lin(32'h980, 32'hB80, 16, "R3");
        walk(32'h060, 1, 0, "chain");

        // R6: zero-length copy makes no access
        put(32'h070, 32'h8000_0000 | (32'h240 >> 3));
        lin_desc(32'h240, 1, 32'h9A0, 32'hBA0, 0);
        walk(32'h070, 0, 0, "zero-len");
        chk(mem[32'hBA0 >> 2] == 32'(32'hBA0 >> 2) * 32'h9E37_79B1 + 32'h1234_5671, "R6",
            "zero-length destination untouched", mem[32'hBA0 >> 2],
            32'(32'hBA0 >> 2) * 32'h9E37_79B1 + 32'h1234_5671);

        // R7: zero source row count, nonzero destination count
        put(32'h078, 32'h8000_0000 | (32'h260 >> 3));
        box_desc(32'h260, 1, 32'h9C0, 32'hBC0, (4 << 16) | 4, 32'h5, 32'h0);
        walk(32'h078, 0, 0, "zero-rows");
        chk(overrun == 1'b1, "R10", "overrun still set", 32'(overrun), 32'h1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule